// File: doc/BRIEF.md
# Register Rename Unit

This block turns up to four decoded instructions per cycle from logical register names into physical register names. The instructions arrive in program order and belong to one hardware thread. Every thread keeps its own logical-to-physical map table, and all threads draw on one shared pool of physical registers. A source operand reads its current mapping. A destination takes a new physical register from a shared FIFO free list, and the block also reports the mapping that destination held before, so the commit logic can hand it back later.

A source can name a register that an older instruction in the same group writes. In that case it takes the tag just given to that writer, not the value in the map table. If the group needs more free registers than are available, the whole group is held and no instruction in it is renamed. When an instruction commits, its old destination mapping returns to the back of the free list. Up to four registers can be released per cycle, and a released register can be allocated from the following cycle on. Stores carry no destination and use no physical register.

With the defaults (32 logical registers, 2 threads, 4 spare physical registers) the block has 68 physical registers, P0 to P67.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register n of thread t maps to physical register t*32+n. The free list holds P64, P65, P66, P67 in that order.
- R2: A source that no older slot in its group writes returns the map-table entry of the group's thread for that logical register.
- R3: The destination-carrying slots of an accepted group are served in slot order (slot 0 first). Each takes the next tag from the head of the free list. A slot whose destination-valid bit is 0 takes no tag and does not advance the list. outValid[i] is 1 for each valid slot of an accepted group.
- R4: A source in slot i that is written by an older slot j<i of the same group returns the tag allocated to the youngest such slot j.
- R5: outPrevDst of a destination slot is the mapping that its logical destination held just before this instruction. This includes writes by older slots of the same group.
- R6: When the number of valid destination slots is larger than the number of free registers, stall is 1 and every outValid bit is 0. Neither map tables nor the free list change. A group that needs no register never stalls.
- R7: A tag on a commit port with cmtValid set goes to the tail of the free list, in commit-slot order. It can be allocated in the next cycle, but not in the cycle of the commit.
- R8: At acceptance, the map table is updated slot by slot, so the youngest writer of a logical register in the group sets its mapping.
- R9: Renaming in one thread never changes the map table of another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 4 | Per-slot instruction valid, slot 0 oldest |
| inThread | input | 1 | Thread of the whole group |
| inDstValid | input | 4 | Per-slot destination present (0 for stores) |
| inDst | input | 4x5 | Logical destination per slot |
| inSrcA | input | 4x5 | Logical first source per slot |
| inSrcB | input | 4x5 | Logical second source per slot |
| cmtValid | input | 4 | Per-port release strobe |
| cmtPhys | input | 4x7 | Physical tag released per port |
| outValid | output | 4 | Slot renamed this cycle |
| outSrcA | output | 4x7 | Physical first source |
| outSrcB | output | 4x7 | Physical second source |
| outDst | output | 4x7 | Newly allocated destination tag |
| outPrevDst | output | 4x7 | Previous mapping of the destination |
| stall | output | 1 | Group held for lack of free registers |

## Verification
The assertions assume that every released tag is one the block earlier reported as a previous mapping, and that no tag is released twice. Under that assumption the free list can never hold more than the spare count. The stimulus keeps to this by drawing every commit from a queue of previous mappings returned by accepted groups, oldest first, so it never invents a tag. Random groups mix thread IDs and draw register numbers from a narrow range, so that bypasses within a group are common. Commit rates are varied so the bench sees both starved and refilled free lists.

// File: rtl/rename_pkg.sv
package rename_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic fire;   // group accepted: update map tables
    logic push;   // at least one release this cycle
  } rnStrobe_t;

  function automatic int unsigned countBits(input logic [31:0] v, input int unsigned n);
    int unsigned c;
    c = 0;
    for (int i = 0; i < 32; i++) if (i < int'(n) && v[i]) c++;
    return c;
  endfunction
endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
#(
  parameter int W     = 4,
  parameter int DEPTH = 4,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [W-1:0]         inValid,
  input  logic [W-1:0]         inDstValid,
  input  logic [W-1:0]         cmtValid,
  output rnStrobe_t            strobe,
  output logic [W-1:0][IW-1:0] allocIdx,
  output logic [W-1:0][IW-1:0] pushIdx,
  output logic                 stall
);
  logic [IW-1:0] headPtr, tailPtr;
  logic [CW-1:0] freeCount;
  int unsigned   needCnt, pushCnt, popCnt;

  function automatic logic [IW-1:0] wrapAdd(input logic [IW-1:0] b, input int unsigned k);
    int unsigned s;
    s = int'(b) + k;
    return IW'(s % DEPTH);
  endfunction

  always_comb begin
    int unsigned n;
    int unsigned m;
    n = 0;
    m = 0;
    for (int i = 0; i < W; i++) begin
      allocIdx[i] = wrapAdd(headPtr, n);
      if (inValid[i] && inDstValid[i]) n++;
      pushIdx[i] = wrapAdd(tailPtr, m);
      if (cmtValid[i]) m++;
    end
    needCnt     = n;
    pushCnt     = m;
    stall       = needCnt > int'(freeCount);
    strobe.fire = !stall;
    strobe.push = (m != 0);
    popCnt      = stall ? 0 : needCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      freeCount <= CW'(DEPTH);
    end else begin
      headPtr   <= wrapAdd(headPtr, popCnt);
      tailPtr   <= wrapAdd(tailPtr, pushCnt);
      freeCount <= CW'(int'(freeCount) - int'(popCnt) + int'(pushCnt));
    end
  end

  // R7: releases never push the list beyond its capacity
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (int'(freeCount) - int'(popCnt) + int'(pushCnt)) <= DEPTH);
  // R6: free count stays within the spare pool
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    int'(freeCount) <= DEPTH);
  // R6: a stalled cycle never consumes free registers
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> int'(freeCount) >= int'($past(freeCount)));
endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
#(
  parameter int W     = 4,
  parameter int L     = 32,
  parameter int T     = 2,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(L),
  localparam int NP   = T * L + DEPTH,
  localparam int PW   = $clog2(NP),
  localparam int TW   = (T > 1) ? $clog2(T) : 1,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rnStrobe_t            strobe,
  input  logic [W-1:0][IW-1:0] allocIdx,
  input  logic [W-1:0][IW-1:0] pushIdx,
  input  logic [W-1:0]         inValid,
  input  logic [TW-1:0]        inThread,
  input  logic [W-1:0]         inDstValid,
  input  logic [W-1:0][LW-1:0] inDst,
  input  logic [W-1:0][LW-1:0] inSrcA,
  input  logic [W-1:0][LW-1:0] inSrcB,
  input  logic [W-1:0]         cmtValid,
  input  logic [W-1:0][PW-1:0] cmtPhys,
  output logic [W-1:0][PW-1:0] outSrcA,
  output logic [W-1:0][PW-1:0] outSrcB,
  output logic [W-1:0][PW-1:0] outDst,
  output logic [W-1:0][PW-1:0] outPrevDst
);
  logic [PW-1:0] mapTbl  [T][L];
  logic [PW-1:0] freeMem [DEPTH];
  logic [W-1:0][PW-1:0] newTag;
  logic [W-1:0] writes;

  assign writes = inValid & inDstValid;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      newTag[i]     = freeMem[allocIdx[i]];
      outSrcA[i]    = mapTbl[inThread][inSrcA[i]];
      outSrcB[i]    = mapTbl[inThread][inSrcB[i]];
      outPrevDst[i] = mapTbl[inThread][inDst[i]];
      // older slots in ascending order: the youngest earlier writer wins
      for (int j = 0; j < i; j++) begin
        if (writes[j] && inDst[j] == inSrcA[i]) outSrcA[i]    = newTag[j];
        if (writes[j] && inDst[j] == inSrcB[i]) outSrcB[i]    = newTag[j];
        if (writes[j] && inDst[j] == inDst[i])  outPrevDst[i] = newTag[j];
      end
      outDst[i] = writes[i] ? newTag[i] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < T; t++)
        for (int n = 0; n < L; n++)
          mapTbl[t][n] <= PW'(t * L + n);
      for (int k = 0; k < DEPTH; k++)
        freeMem[k] <= PW'(T * L + k);
    end else begin
      if (strobe.fire)
        for (int i = 0; i < W; i++)
          if (writes[i]) mapTbl[inThread][inDst[i]] <= newTag[i];
      if (strobe.push)
        for (int k = 0; k < W; k++)
          if (cmtValid[k]) freeMem[pushIdx[k]] <= cmtPhys[k];
    end
  end

  // R3: tags handed out in one accepted group are all distinct
  generate
    for (genvar a = 0; a < W; a++) begin : g_da
      for (genvar b = a + 1; b < W; b++) begin : g_db
        p_alloc_distinct_r3: assert property (@(posedge clk) disable iff (!rstN)
          (strobe.fire && writes[a] && writes[b]) |-> newTag[a] != newTag[b]);
      end
      // R5: a source naming its own destination sees the same old mapping
      p_prev_matches_src_r5: assert property (@(posedge clk) disable iff (!rstN)
        (inValid[a] && inDstValid[a] && inSrcA[a] == inDst[a]) |-> outSrcA[a] == outPrevDst[a]);
    end
  endgenerate
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
#(
  parameter int W     = 4,
  parameter int L     = 32,
  parameter int T     = 2,
  parameter int SPARE = 4,
  localparam int LW   = $clog2(L),
  localparam int PW   = $clog2(T * L + SPARE),
  localparam int TW   = (T > 1) ? $clog2(T) : 1,
  localparam int IW   = (SPARE > 1) ? $clog2(SPARE) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [W-1:0]         inValid,
  input  logic [TW-1:0]        inThread,
  input  logic [W-1:0]         inDstValid,
  input  logic [W-1:0][LW-1:0] inDst,
  input  logic [W-1:0][LW-1:0] inSrcA,
  input  logic [W-1:0][LW-1:0] inSrcB,
  input  logic [W-1:0]         cmtValid,
  input  logic [W-1:0][PW-1:0] cmtPhys,
  output logic [W-1:0]         outValid,
  output logic [W-1:0][PW-1:0] outSrcA,
  output logic [W-1:0][PW-1:0] outSrcB,
  output logic [W-1:0][PW-1:0] outDst,
  output logic [W-1:0][PW-1:0] outPrevDst,
  output logic                 stall
);
  rnStrobe_t            strobe;
  logic [W-1:0][IW-1:0] allocIdx, pushIdx;

  rename_ctrl #(.W(W), .DEPTH(SPARE)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDstValid(inDstValid),
    .cmtValid(cmtValid), .strobe(strobe), .allocIdx(allocIdx),
    .pushIdx(pushIdx), .stall(stall));

  rename_datapath #(.W(W), .L(L), .T(T), .DEPTH(SPARE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .allocIdx(allocIdx),
    .pushIdx(pushIdx), .inValid(inValid), .inThread(inThread),
    .inDstValid(inDstValid), .inDst(inDst), .inSrcA(inSrcA), .inSrcB(inSrcB),
    .cmtValid(cmtValid), .cmtPhys(cmtPhys), .outSrcA(outSrcA),
    .outSrcB(outSrcB), .outDst(outDst), .outPrevDst(outPrevDst));

  assign outValid = inValid & {W{strobe.fire}};
endmodule

// File: tb/rename_unit_tb.sv
module rename_unit_tb;
  localparam int W = 4, L = 32, T = 2, S = 4;
  localparam int LW = $clog2(L), PW = $clog2(T * L + S), TW = 1;

  logic clk = 0, rstN = 0;
  logic [W-1:0] inValid = '0, inDstValid = '0, cmtValid = '0;
  logic [TW-1:0] inThread = '0;
  logic [W-1:0][LW-1:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic [W-1:0][PW-1:0] cmtPhys = '0;
  logic [W-1:0] outValid;
  logic [W-1:0][PW-1:0] outSrcA, outSrcB, outDst, outPrevDst;
  logic stall;

  rename_unit u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int mapM [T][L];
  int freeQ[$];
  int pend[$];
  bit [W-1:0] stV, stDv;
  int stThr, stCmt;
  int stDst[W], stSa[W], stSb[W];
  string labSrc = "R2", labStall = "R6";

  task automatic chk(input string lab, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", lab, got, exp);
    end
  endtask

  task automatic resetModel();
    for (int t = 0; t < T; t++) for (int n = 0; n < L; n++) mapM[t][n] = t * L + n;
    freeQ.delete(); pend.delete();
    for (int k = 0; k < S; k++) freeQ.push_back(T * L + k);
  endtask

  task automatic step();
    int cmtTags[$];
    int newT[W];
    int need, expA, expB, expP;
    bit bypA, bypB;
    bit expStall;
    @(negedge clk);
    inValid = stV; inDstValid = stDv; inThread = TW'(stThr);
    for (int i = 0; i < W; i++) begin
      inDst[i] = LW'(stDst[i]); inSrcA[i] = LW'(stSa[i]); inSrcB[i] = LW'(stSb[i]);
      if (i < stCmt && pend.size() > 0) begin
        cmtValid[i] = 1'b1; cmtPhys[i] = PW'(pend[0]);
        cmtTags.push_back(pend.pop_front());
      end else begin
        cmtValid[i] = 1'b0; cmtPhys[i] = '0;
      end
    end
    #1;
    need = 0;
    for (int i = 0; i < W; i++) if (stV[i] && stDv[i]) begin newT[i] = freeQ[need]; need++; end
    expStall = need > freeQ.size();
    chk({labStall, " stall"}, int'(stall), int'(expStall));
    for (int i = 0; i < W; i++) begin
      if (!stV[i]) continue;
      chk(expStall ? "R6 outValid" : "R3 outValid", int'(outValid[i]), int'(!expStall));
      if (expStall) continue;
      expA = mapM[stThr][stSa[i]]; expB = mapM[stThr][stSb[i]]; expP = mapM[stThr][stDst[i]];
      bypA = 0; bypB = 0;
      for (int j = 0; j < i; j++) if (stV[j] && stDv[j]) begin
        if (stDst[j] == stSa[i]) begin expA = newT[j]; bypA = 1; end
        if (stDst[j] == stSb[i]) begin expB = newT[j]; bypB = 1; end
        if (stDst[j] == stDst[i]) expP = newT[j];
      end
      chk(bypA ? "R4 srcA" : {labSrc, " srcA"}, int'(outSrcA[i]), expA);
      chk(bypB ? "R4 srcB" : {labSrc, " srcB"}, int'(outSrcB[i]), expB);
      if (stDv[i]) begin
        chk("R3 dst", int'(outDst[i]), newT[i]);
        chk("R5 prevDst", int'(outPrevDst[i]), expP);
      end
    end
    @(posedge clk);
    if (!expStall) begin
      for (int i = 0; i < W; i++) if (stV[i] && stDv[i]) begin
        pend.push_back(mapM[stThr][stDst[i]]);
        mapM[stThr][stDst[i]] = newT[i];   // R8: youngest writer applied last
        void'(freeQ.pop_front());
      end
    end
    foreach (cmtTags[k]) freeQ.push_back(cmtTags[k]);
  endtask

  task automatic setSlot(input int i, input bit v, input bit dv, input int d, input int a, input int b);
    stV[i] = v; stDv[i] = dv; stDst[i] = d; stSa[i] = a; stSb[i] = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    resetModel();
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chk("R6 reset stall", int'(stall), 0);
    chk("R6 reset outValid", int'(outValid), 0);
    // R1: reset mappings of both threads
    labSrc = "R1"; stCmt = 0;
    for (int t = 0; t < T; t++) begin
      stThr = t;
      for (int i = 0; i < W; i++) setSlot(i, 1, 0, 0, i * 7 + 3, i * 5 + 1);
      step();
    end
    // R3/R4/R5: dependent group, slot 3 a store
    stThr = 0;
    setSlot(0, 1, 1, 1, 2, 3);
    setSlot(1, 1, 1, 2, 1, 0);
    setSlot(2, 1, 1, 2, 2, 9);
    setSlot(3, 1, 0, 0, 1, 3);
    labSrc = "R2"; step();
    // R7: one free, two needed, release in same cycle still stalls
    setSlot(0, 1, 1, 5, 1, 5); setSlot(1, 1, 1, 6, 5, 2);
    setSlot(2, 0, 0, 0, 0, 0); setSlot(3, 0, 0, 0, 0, 0);
    labStall = "R7"; stCmt = 1; step();
    stCmt = 0; step();   // R7: released tag now usable
    labStall = "R6";
    // R8: youngest writer wins, read back in next group
    for (int i = 0; i < W; i++) setSlot(i, 1, 0, 0, 1 + i % 2, 5 + i % 2);
    labSrc = "R8"; step();
    // R9: other thread untouched
    stThr = 1; labSrc = "R9"; step();
    labSrc = "R2";
    // random phase
    for (int c = 0; c < 4000; c++) begin
      int mode;
      mode = $urandom_range(0, 3);
      stThr = $urandom_range(0, T - 1);
      for (int i = 0; i < W; i++) begin
        int rng;
        rng = (mode == 0) ? L - 1 : 7;
        setSlot(i, $urandom_range(0, 4) != 0, $urandom_range(0, 3) != 0,
                $urandom_range(0, rng), $urandom_range(0, rng), $urandom_range(0, rng));
      end
      stCmt = (mode == 1) ? 0 : $urandom_range(0, 4);
      labSrc = (c % 2 == 0) ? "R9" : "R8";
      step();
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule